// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

An 8-bit general-purpose I/O port for a small microcontroller-style core. Each pad is modelled as three wires: the value the port drives, an enable for that drive, and the level seen on the pad. A direction register selects per pin whether the pad is driven from an output latch or left floating so that an external level can be read. Pad input levels pass through a two-flop synchronizer before the port samples them.

A simple bus reaches three register addresses: the live pin levels, the output latch and the direction register. Each accepted request is a full-byte read, a full-byte write, or a single-bit set or clear. Every request takes one four-phase instruction cycle and is carried out as read-modify-write. The source byte is sampled in the second phase and the write lands at the third-phase edge. Bit operations on the pin address rebuild the whole latch from the sampled pin levels. This deliberately reproduces the hazard in which an input pin held high silently sets its own latch bit. The latch address offers a safe path for the same operations.

An open-drain style line is built by holding a latch bit at 0 and toggling only its direction bit.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset every direction bit is 1, every latch bit is 0, and `pad_oe_o` is all zeros.
- R2: A pin with direction 0 has `pad_oe_o` high and drives its latch bit on `pad_out_o`. A pin with direction 1 has `pad_oe_o` low. `pad_out_o` always equals the latch.
- R3: Writing the direction register, as a byte or a bit, never changes the output latch.
- R4: Reads use `op_i`=0. A read of address 0 (pins) returns the synchronized pad levels. A read of address 1 returns the latch and a read of address 2 returns the direction register. No read changes the latch or the direction register.
- R5: Set (`op_i`=2) and clear (`op_i`=3) on address 0 sample all pin levels and change only bit `bit_i`. The whole result is written into the latch, so an input pin held high sets its latch bit and an input pin held low clears it.
- R6: Set and clear on address 1 change only latch bit `bit_i`. On address 2 they change only direction bit `bit_i`.
- R7: A byte write (`op_i`=1) to address 0 or 1 loads `wdata_i` into the latch. To address 2 it loads the direction register.
- R8: The phase counter is 0 while `cycle_start_o` is high. A request is accepted only on a rising edge where `cycle_start_o` is high; `req_i` at any other edge is ignored. Relative to that accepting edge A, `rdata_o` and a one-cycle `rvalid_o` appear after edge A+1. Register writes become visible on the pads after edge A+2 and not before.
- R9: A pad level must have been present for two rising edges before the sample edge A+1 to be seen by a pin read. A change made in the cycle of the accepting edge is not yet visible.
- R10: With a latch bit at 0, toggling only its direction bit switches the pad between driving low and released, and the latch bit stays 0.
- R11: Address 3 is unused. Reads of it return 0, and writes or bit operations to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, sampled at cycle start |
| addr_i | input | 2 | 0 pins, 1 latch, 2 direction, 3 unused |
| op_i | input | 2 | 0 read, 1 write byte, 2 set bit, 3 clear bit |
| bit_i | input | 3 | Bit index for set and clear |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, held until the next read |
| rvalid_o | output | 1 | One-cycle pulse when rdata_o is updated |
| cycle_start_o | output | 1 | High in phase 0, when a request may be accepted |
| pad_in_i | input | 8 | Level present on each pad |
| pad_out_o | output | 8 | Value driven on each pad |
| pad_oe_o | output | 8 | Drive enable of each pad |

## Verification
The pads are modelled as driven bits ORed with external pull levels. Byte writes, reads and bit operations are exercised on each address with mixed direction patterns. The key pair of cases is a pulled-up input with latch 0 next to a bit operation. Sent to the pin address, it must flip that latch bit to 1. Sent to the latch address, it must leave the bit at 0. A clear on the pin address next to a low input shows the mirror case. Further cases change a pad level in the accepting cycle and one cycle earlier to separate the synchronizer delay from the sample point. They also check the pad outputs one cycle before and after the write phase, send a request in a wrong phase, and touch the unused address.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_PIN  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } gp_sel_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_SET = 2'd2,
    OP_CLR = 2'd3
  } gp_op_e;
endpackage

// File: rtl/gpio_phase_gen.sv
module gpio_phase_gen #(
  parameter int PHASES = 4,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            start_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else if (ph_q == PH_W'(PHASES - 1)) ph_q <= '0;
    else ph_q <= ph_q + PH_W'(1);
  end

  assign ph_o    = ph_q;
  assign start_o = (ph_q == '0);

  p_phase_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_W'(PHASES - 1)) |=> (ph_q == '0));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else stg_q[s] <= pad_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    p_sync_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd3) |-> (sync_o == $past(pad_i, 2)));
  end
endmodule

// File: rtl/gpio_cmd_exec.sv
module gpio_cmd_exec
  import gpio_port_pkg::*;
#(
  parameter int W     = 8,
  parameter int PH_W  = 2,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  ph_i,
  input  logic             req_i,
  input  gp_sel_e          sel_i,
  input  gp_op_e           op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     pin_i,
  input  logic [W-1:0]     lat_i,
  input  logic [W-1:0]     dir_i,
  output logic             lat_we_o,
  output logic             dir_we_o,
  output logic [W-1:0]     nxt_o,
  output logic [W-1:0]     rdata_o,
  output logic             rvalid_o
);
  localparam logic [PH_W-1:0] PH_ACC = PH_W'(0);
  localparam logic [PH_W-1:0] PH_SMP = PH_W'(1);
  localparam logic [PH_W-1:0] PH_WR  = PH_W'(2);
  localparam logic [PH_W-1:0] PH_END = PH_W'(3);

  logic             cmd_vld_q;
  gp_sel_e          sel_q;
  gp_op_e           op_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     wd_q;
  logic [W-1:0]     base_q;
  logic [W-1:0]     rdata_q;
  logic             rvalid_q;
  logic [W-1:0]     src;
  logic [W-1:0]     mask;
  logic             wr_slot;

  // command capture at the accept phase only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_q <= 1'b0;
      sel_q     <= SEL_NONE;
      op_q      <= OP_RD;
      idx_q     <= '0;
      wd_q      <= '0;
    end else if (ph_i == PH_ACC) begin
      cmd_vld_q <= req_i;
      sel_q     <= sel_i;
      op_q      <= op_i;
      idx_q     <= idx_i;
      wd_q      <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_PIN: src = pin_i;
      SEL_LAT: src = lat_i;
      SEL_DIR: src = dir_i;
      default: src = '0;
    endcase
  end

  // sample phase: capture source byte and read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      if (ph_i == PH_SMP && cmd_vld_q) begin
        base_q <= src;
        if (op_q == OP_RD) begin
          rdata_q  <= src;
          rvalid_q <= 1'b1;
        end
      end
    end
  end

  assign mask = W'(1) << idx_q;

  always_comb begin
    unique case (op_q)
      OP_WR:   nxt_o = wd_q;
      OP_SET:  nxt_o = base_q | mask;
      OP_CLR:  nxt_o = base_q & ~mask;
      default: nxt_o = base_q;
    endcase
  end

  assign wr_slot  = cmd_vld_q && (ph_i == PH_WR) && (op_q != OP_RD);
  assign lat_we_o = wr_slot && (sel_q == SEL_PIN || sel_q == SEL_LAT);
  assign dir_we_o = wr_slot && (sel_q == SEL_DIR);
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_accept_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_vld_q) |-> (ph_i == PH_SMP));

  p_latch_bitop_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_we_o && sel_q == SEL_LAT && op_q != OP_WR) |-> ($countones(nxt_o ^ lat_i) <= 1));

  p_dir_bitop_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_we_o && op_q != OP_WR) |-> ($countones(nxt_o ^ dir_i) <= 1));

  p_read_keeps_state_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i == PH_END && cmd_vld_q && op_q == OP_RD) |-> ($stable(lat_i) && $stable(dir_i)));

  p_unused_addr_inert_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i == PH_END && cmd_vld_q && sel_q == SEL_NONE) |-> ($stable(lat_i) && $stable(dir_i)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lat_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] lat_q;
  logic [W-1:0] dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (lat_we_i) lat_q <= nxt_i;
  end

  // direction 1 = input; all pins start as inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= '1;
    else if (dir_we_i) dir_q <= nxt_i;
  end

  assign lat_o = lat_q;
  assign dir_o = dir_q;

  p_dir_wr_keeps_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_we_i && !lat_we_i) |=> $stable(lat_q));

  p_one_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lat_we_i && dir_we_i));
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_port_pkg::*;
#(
  parameter int W       = 8,
  parameter int PHASES  = 4,
  parameter int SYNC_FF = 2,
  localparam int IDX_W  = $clog2(W),
  localparam int PH_W   = $clog2(PHASES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       addr_i,
  input  logic [1:0]       op_i,
  input  logic [IDX_W-1:0] bit_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output logic             rvalid_o,
  output logic             cycle_start_o,
  input  logic [W-1:0]     pad_in_i,
  output logic [W-1:0]     pad_out_o,
  output logic [W-1:0]     pad_oe_o
);
  logic [PH_W-1:0] ph;
  logic [W-1:0]    pin_sync;
  logic [W-1:0]    lat;
  logic [W-1:0]    dir;
  logic [W-1:0]    nxt;
  logic            lat_we;
  logic            dir_we;

  gpio_phase_gen #(.PHASES(PHASES)) i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_o    (ph),
    .start_o (cycle_start_o)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_FF)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_in_i),
    .sync_o (pin_sync)
  );

  gpio_cmd_exec #(.W(W), .PH_W(PH_W), .IDX_W(IDX_W)) i_exec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_i     (ph),
    .req_i    (req_i),
    .sel_i    (gp_sel_e'(addr_i)),
    .op_i     (gp_op_e'(op_i)),
    .idx_i    (bit_i),
    .wdata_i  (wdata_i),
    .pin_i    (pin_sync),
    .lat_i    (lat),
    .dir_i    (dir),
    .lat_we_o (lat_we),
    .dir_we_o (dir_we),
    .nxt_o    (nxt),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  gpio_port_regs #(.W(W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lat_we_i (lat_we),
    .dir_we_i (dir_we),
    .nxt_i    (nxt),
    .lat_o    (lat),
    .dir_o    (dir)
  );

  assign pad_out_o = lat;
  assign pad_oe_o  = ~dir;

  p_state_moves_in_write_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(lat) || !$stable(dir)) |-> (ph == PH_W'(3)));

  p_rvalid_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (ph == PH_W'(2)));
endmodule

// File: tb/test_gpio_rmw_port.sv
module test_gpio_rmw_port;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] addr = '0;
  logic [1:0] op = '0;
  logic [2:0] bidx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rvalid;
  logic       cstart;
  logic [7:0] pad_in, pad_out, pad_oe;
  logic [7:0] ext_m = 8'h00;

  // external world: driven pins follow the port, others follow pull levels
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_m);

  gpio_rmw_port i_gpio_rmw_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .op_i(op),
    .bit_i(bidx), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .cycle_start_o(cstart), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] lat_m = 8'h00;
  logic [7:0] dir_m = 8'hFF;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pins_m();
    return (~dir_m & lat_m) | (dir_m & ext_m);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4 unexpected read actual=%02h expected=none", rdata);
      end else begin
        chk8(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_op(input logic [1:0] a, input logic [1:0] o, input logic [2:0] b,
                       input logic [7:0] d, input string tag,
                       input bit ext_at_req = 1'b0, input logic [7:0] ext_new = 8'h00);
    logic [7:0] base, nv, lat_n, dir_n;
    @(negedge clk);
    while (!cstart) @(negedge clk);
    case (a)
      2'd0: base = pins_m();
      2'd1: base = lat_m;
      2'd2: base = dir_m;
      default: base = 8'h00;
    endcase
    case (o)
      2'd1: nv = d;
      2'd2: nv = base | (8'h01 << b);
      2'd3: nv = base & ~(8'h01 << b);
      default: nv = base;
    endcase
    lat_n = lat_m; dir_n = dir_m;
    if (o != 2'd0) begin
      if (a == 2'd0 || a == 2'd1) lat_n = nv;
      else if (a == 2'd2) dir_n = nv;
    end
    if (o == 2'd0) begin
      exp_q.push_back(base);
      tag_q.push_back(tag);
    end
    if (ext_at_req) ext_m = ext_new;
    req = 1'b1; addr = a; op = o; bidx = b; wdata = d;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk8({tag, " R8 pads before write phase"}, pad_out, lat_m);
    chk8({tag, " R8 oe before write phase"}, pad_oe, ~dir_m);
    @(negedge clk);
    lat_m = lat_n; dir_m = dir_n;
    chk8({tag, " R2 pad_out"}, pad_out, lat_m);
    chk8({tag, " R2 pad_oe"}, pad_oe, ~dir_m);
  endtask

  task automatic set_ext(input logic [7:0] v);
    ext_m = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk8("R1 reset pad_oe", pad_oe, 8'h00);
    chk8("R1 reset pad_out", pad_out, 8'h00);
    rst_n = 1'b1;
    do_op(2'd2, 2'd0, 3'd0, 8'h00, "R1 reset dir read");
    chk8("R1 reset dir literal", dir_m, 8'hFF);
    do_op(2'd1, 2'd0, 3'd0, 8'h00, "R1 reset latch read");

    // R4 / R9 pin reads and synchronizer latency
    set_ext(8'hA5);
    do_op(2'd0, 2'd0, 3'd0, 8'h00, "R4 pin read A5");
    do_op(2'd0, 2'd0, 3'd0, 8'h00, "R9 change at accept unseen", 1'b1, 8'h3C);
    do_op(2'd0, 2'd0, 3'd0, 8'h00, "R9 settled change seen");
    ext_m = 8'hC3; // set one cycle before accept: must be seen
    do_op(2'd0, 2'd0, 3'd0, 8'h00, "R9 two-edge lead seen");

    // R7 latch write; inputs still read external levels
    do_op(2'd1, 2'd1, 3'd0, 8'h5A, "R7 latch write");
    do_op(2'd1, 2'd0, 3'd0, 8'h00, "R7 latch readback");
    do_op(2'd0, 2'd0, 3'd0, 8'h00, "R4 pins not latch");
    do_op(2'd0, 2'd1, 3'd0, 8'h66, "R7 pin-address write");
    do_op(2'd1, 2'd0, 3'd0, 8'h00, "R7 pin-address write readback");

    // R2 / R3 direction
    do_op(2'd2, 2'd1, 3'd0, 8'h0F, "R2 dir write 0F");
    chk8("R2 oe literal", pad_oe, 8'hF0);
    do_op(2'd0, 2'd0, 3'd0, 8'h00, "R2 mixed pin read");
    do_op(2'd2, 2'd1, 3'd0, 8'hFF, "R3 dir all input");
    do_op(2'd2, 2'd1, 3'd0, 8'h00, "R3 dir all output");
    chk8("R3 latch kept", pad_out, 8'h66);
    do_op(2'd1, 2'd0, 3'd0, 8'h00, "R3 latch read after dir writes");

    // R5 hazard: bit1 input pulled high, latch bit1 = 0
    do_op(2'd1, 2'd1, 3'd0, 8'h00, "R5 setup latch");
    do_op(2'd2, 2'd1, 3'd0, 8'h02, "R5 setup dir");
    set_ext(8'hFF);
    do_op(2'd0, 2'd2, 3'd0, 8'h00, "R5 set bit0 on pins");
    do_op(2'd1, 2'd0, 3'd0, 8'h00, "R5 latch read after pin bitop");
    chk8("R5 latch bit1 flipped to 1", pad_out, 8'h03);
    do_op(2'd2, 2'd3, 3'd1, 8'h00, "R5 make bit1 output");
    chk8("R5 bit1 now drives high", pad_out & pad_oe, 8'h03);

    // R6 same neighbour op via latch address is safe
    do_op(2'd1, 2'd1, 3'd0, 8'h00, "R6 setup latch");
    do_op(2'd2, 2'd1, 3'd0, 8'h02, "R6 setup dir");
    do_op(2'd1, 2'd2, 3'd0, 8'h00, "R6 set bit0 on latch");
    do_op(2'd1, 2'd0, 3'd0, 8'h00, "R6 latch read");
    chk8("R6 latch bit1 stays 0", pad_out, 8'h01);

    // R5 mirror: input held low clears its latch bit
    do_op(2'd1, 2'd1, 3'd0, 8'hFF, "R5 setup latch FF");
    do_op(2'd2, 2'd1, 3'd0, 8'h20, "R5 bit5 input");
    set_ext(8'h00);
    do_op(2'd0, 2'd3, 3'd2, 8'h00, "R5 clear bit2 on pins");
    chk8("R5 latch bit5 cleared", pad_out, 8'hDB);
    do_op(2'd1, 2'd3, 3'd7, 8'h00, "R6 clear bit7 on latch");
    chk8("R6 latch only bit7", pad_out, 8'h5B);

    // R6 on direction
    do_op(2'd2, 2'd2, 3'd4, 8'h00, "R6 set dir bit4");
    chk8("R6 dir bit4 only", pad_oe, 8'hCF);

    // R10 open-drain line on bit3
    set_ext(8'hFF);
    do_op(2'd1, 2'd1, 3'd0, 8'h00, "R10 latch zero");
    do_op(2'd2, 2'd1, 3'd0, 8'hFF, "R10 release all");
    do_op(2'd2, 2'd3, 3'd3, 8'h00, "R10 drive bit3 low");
    chk8("R10 bit3 driven low", {pad_oe[3], pad_out[3]}, 8'h02);
    do_op(2'd0, 2'd0, 3'd0, 8'h00, "R10 line low seen");
    do_op(2'd2, 2'd2, 3'd3, 8'h00, "R10 release bit3");
    do_op(2'd0, 2'd0, 3'd0, 8'h00, "R10 line pulled up");
    do_op(2'd2, 2'd3, 3'd3, 8'h00, "R10 drive again");
    chk8("R10 still low", {pad_oe[3], pad_out[3]}, 8'h02);

    // R11 unused address
    do_op(2'd3, 2'd1, 3'd0, 8'hFF, "R11 write unused");
    do_op(2'd3, 2'd2, 3'd5, 8'h00, "R11 set unused");
    do_op(2'd3, 2'd0, 3'd0, 8'h00, "R11 read unused");
    do_op(2'd1, 2'd0, 3'd0, 8'h00, "R11 latch untouched");
    do_op(2'd2, 2'd0, 3'd0, 8'h00, "R11 dir untouched");

    // R8 request outside phase 0 is ignored
    @(negedge clk);
    while (!cstart) @(negedge clk);
    @(negedge clk);
    req = 1'b1; addr = 2'd1; op = 2'd1; wdata = 8'hEE;
    @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
    chk8("R8 off-phase req ignored", pad_out, lat_m);
    do_op(2'd1, 2'd0, 3'd0, 8'h00, "R8 latch after off-phase req");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule